// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block turns a few digital health signals into a processor reset. A low-line flag, meaning the supply has sagged below its trip point, drives the reset active at once. When the flag clears, the reset stays active for a fixed number of time-base ticks. A watchdog watches one input level. If that level sits still for a whole timeout period, the block raises a fault output and issues a full reset pulse. The pulse repeats for every later period in which the watchdog goes unserviced.

The time base comes from one of two sources. One is an internal divider of the system clock. The other is an externally supplied tick, which is synchronized and edge-detected. A separate flag models a floating watchdog pin, and it disables the watchdog. A chip-enable input passes through to the memory side only while the supply is good.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While `low_line` is 1, `rst_out_n` is 0 in the same cycle.
- R2: After `low_line` returns to 0, `rst_out_n` stays 0 until `RST_TICKS` time-base ticks have passed, then goes to 1.
- R3: With the watchdog enabled and reset released, if `wd_in` holds one level for `WD_TICKS` ticks, reset is asserted for `RST_TICKS` ticks. This repeats for every further `WD_TICKS` ticks without service.
- R4: Each transition of `wd_in`, rising or falling, restarts the watchdog count from zero.
- R5: While `wd_float` is 1, the watchdog never times out.
- R6: `wd_out_n` goes to 0 on a watchdog timeout and stays there. It returns to 1 after any `wd_in` transition, or while `low_line` is 1.
- R7: `rst_out` is always the inverse of `rst_out_n`.
- R8: With `osc_sel`=1, the tick is one pulse every `INT_DIV` clocks and `ext_tick` is ignored. With `osc_sel`=0, each rising edge of `ext_tick` is one tick and the internal divider is ignored.
- R9: `ce_out_n` equals `ce_in_n` while `low_line` is 0, and is 1 while `low_line` is 1.
- R10: After module reset `rst_n`, `rst_out_n` is 0 and `wd_out_n` is 1. The reset then lasts `RST_TICKS` ticks.
- R11: The watchdog count is held at zero while reset is active, so the first timeout comes `WD_TICKS` ticks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Module reset, active low |
| low_line | input | 1 | Supply below threshold |
| wd_in | input | 1 | Watchdog input level (asynchronous) |
| wd_float | input | 1 | Watchdog pin floating; disables watchdog |
| osc_sel | input | 1 | 1 = internal tick, 0 = external tick |
| ext_tick | input | 1 | External time base (asynchronous) |
| ce_in_n | input | 1 | Chip enable in, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| wd_out_n | output | 1 | Watchdog fault, active low |
| ce_out_n | output | 1 | Gated chip enable, active low |

## Verification
Two events can land on the same clock: the clearing of the watchdog fault and a reset request. A low-line event during a watchdog-induced reset pulse must both clear `wd_out_n` and reload the reset count. The bench provokes this by raising `low_line` while the fault is set and a reset pulse is running. It then checks that the reset stays active, that `wd_out_n` recovers, and that the release comes a full `RST_TICKS` after the low-line flag drops. Random `low_line` and `ce_in_n` patterns also check the gating and the reset complement on every cycle.

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor #(
  parameter int INT_DIV   = 4,
  parameter int RST_TICKS = 8,
  parameter int WD_TICKS  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_line,
  input  logic wd_in,
  input  logic wd_float,
  input  logic osc_sel,
  input  logic ext_tick,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_out_n,
  output logic ce_out_n
);
  localparam int DW = $clog2(INT_DIV + 1);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam int WW = $clog2(WD_TICKS + 1);

  logic [DW-1:0] div_q;
  logic [RW-1:0] rcnt;
  logic [WW-1:0] wcnt;
  logic [2:0]    wd_sy, xt_sy;
  logic          fault_q;

  logic int_tick, ext_pulse, tick, wd_edge, rst_act, wd_run, timeout;

  assign int_tick  = (div_q == DW'(INT_DIV - 1));
  assign ext_pulse = xt_sy[1] & ~xt_sy[2];
  assign tick      = osc_sel ? int_tick : ext_pulse;
  assign wd_edge   = wd_sy[1] ^ wd_sy[2];
  assign rst_act   = low_line | (rcnt != '0);
  assign wd_run    = !rst_act && !wd_float && !wd_edge;
  assign timeout   = wd_run && tick && (wcnt == WW'(WD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_sy <= '0;
      xt_sy <= '0;
    end else begin
      wd_sy <= {wd_sy[1:0], wd_in};
      xt_sy <= {xt_sy[1:0], ext_tick};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        div_q <= '0;
    else if (int_tick) div_q <= '0;
    else               div_q <= div_q + DW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     rcnt <= RW'(RST_TICKS);
    else if (low_line || timeout)   rcnt <= RW'(RST_TICKS);
    else if (tick && rcnt != '0)    rcnt <= rcnt - RW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 wcnt <= '0;
    else if (!wd_run || timeout) wcnt <= '0;
    else if (tick)              wcnt <= wcnt + WW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    fault_q <= 1'b0;
    else if (low_line || wd_edge)  fault_q <= 1'b0;
    else if (timeout)              fault_q <= 1'b1;

  assign rst_out_n = ~rst_act;
  assign rst_out   = rst_act;
  assign wd_out_n  = ~fault_q;
  assign ce_out_n  = low_line | ce_in_n;

  a_r1_lowline_reset: assert property (@(posedge clk) disable iff (!rst_n)
    low_line |-> !rst_out_n);
  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out != rst_out_n);
  a_r9_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    low_line |-> ce_out_n);
  a_r6_lowline_clears: assert property (@(posedge clk) disable iff (!rst_n)
    low_line |=> wd_out_n);
  a_r5_float_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_out_n) |-> $past(!wd_float));
  a_r3_fault_resets: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_out_n) |-> !rst_out_n);
  a_r2_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (!low_line && $past(!low_line)));
  a_r11_wd_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (wcnt == '0));
endmodule

// File: tb/wdt_reset_supervisor_test.sv
`timescale 1ns/1ps
module wdt_reset_supervisor_test;
  localparam int INT_DIV = 4, RST_TICKS = 8, WD_TICKS = 12;

  logic clk = 0, rst_n = 0;
  logic low_line = 0, wd_in = 0, wd_float = 0, osc_sel = 0, ext_tick = 0, ce_in_n = 1;
  logic rst_out_n, rst_out, wd_out_n, ce_out_n;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wdt_reset_supervisor #(.INT_DIV(INT_DIV), .RST_TICKS(RST_TICKS), .WD_TICKS(WD_TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .low_line(low_line), .wd_in(wd_in), .wd_float(wd_float),
    .osc_sel(osc_sel), .ext_tick(ext_tick), .ce_in_n(ce_in_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_out_n(wd_out_n), .ce_out_n(ce_out_n));

  function automatic logic exp_ce(logic ll, logic ce);
    return ll ? 1'b1 : ce;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1;
      repeat (3) @(negedge clk);
      ext_tick = 0;
      repeat (3) @(negedge clk);
    end
    #0.5;
  endtask

  task automatic toggle_wd();
    @(negedge clk); wd_in = ~wd_in;
    cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    @(negedge clk); rst_n = 1;
    cyc(1);
    chk("R10 reset at power-on", rst_out_n, 0);
    chk("R10 wd_out high at power-on", wd_out_n, 1);
    chk("R7 complement", rst_out, 1);

    cyc(200);
    chk("R8 internal tick ignored with osc_sel=0", rst_out_n, 0);
    pulse(RST_TICKS - 1);
    chk("R2 reset held before last tick", rst_out_n, 0);
    pulse(1);
    chk("R2 R10 reset released", rst_out_n, 1);

    pulse(WD_TICKS - 1);
    chk("R3 no timeout one tick early", rst_out_n, 1);
    chk("R6 wd_out high before timeout", wd_out_n, 1);
    pulse(1);
    chk("R3 timeout asserts reset", rst_out_n, 0);
    chk("R6 wd_out low on timeout", wd_out_n, 0);
    pulse(RST_TICKS);
    chk("R3 timeout pulse ends", rst_out_n, 1);
    chk("R6 fault persists", wd_out_n, 0);
    pulse(WD_TICKS - 1);
    chk("R11 timer restarted at release", rst_out_n, 1);
    pulse(1);
    chk("R3 repeated timeout", rst_out_n, 0);
    pulse(RST_TICKS);
    chk("R3 second pulse ends", rst_out_n, 1);
    toggle_wd();
    chk("R6 transition clears fault", wd_out_n, 1);

    pulse(WD_TICKS - 1); toggle_wd(); pulse(WD_TICKS - 1);
    chk("R4 falling transition restarts timer", rst_out_n, 1);
    pulse(WD_TICKS - 1); toggle_wd(); pulse(WD_TICKS - 1);
    chk("R4 rising transition restarts timer", rst_out_n, 1);
    chk("R4 no fault", wd_out_n, 1);

    @(negedge clk); wd_float = 1;
    pulse(3 * WD_TICKS);
    chk("R5 float disables watchdog", rst_out_n, 1);
    chk("R5 no fault while floating", wd_out_n, 1);

    @(negedge clk); wd_float = 0;
    pulse(1);
    pulse(WD_TICKS);
    chk("R3 timeout before low-line", wd_out_n, 0);
    pulse(2);
    @(negedge clk); low_line = 1; #0.5;
    chk("R1 low-line asserts reset", rst_out_n, 0);
    chk("R9 ce blocked", ce_out_n, 1);
    cyc(2);
    chk("R6 low-line clears fault", wd_out_n, 1);
    @(negedge clk); low_line = 0; wd_float = 1;
    pulse(RST_TICKS - 1);
    chk("R2 full count after low-line", rst_out_n, 0);
    pulse(1);
    chk("R2 released after low-line", rst_out_n, 1);

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      low_line = ($urandom_range(0, 9) < 3);
      ce_in_n  = $urandom_range(0, 1);
      #0.5;
      chk("R9 ce gating", ce_out_n, exp_ce(low_line, ce_in_n));
      chk("R7 complement", rst_out, !rst_out_n);
      if (low_line) chk("R1 low-line reset", rst_out_n, 0);
    end

    @(negedge clk); osc_sel = 1; low_line = 1;
    cyc(3);
    @(negedge clk); low_line = 0;
    cyc((RST_TICKS - 1) * INT_DIV - 1);
    chk("R8 internal tick reset held", rst_out_n, 0);
    cyc(INT_DIV + 2);
    chk("R8 internal tick reset released", rst_out_n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule